// File: doc/BRIEF.md
# Block-Scaled FP4 Dot-Product Accumulator

This unit takes two vectors of 64 four-bit E2M1 numbers per step and forms their dot product. It applies one scale factor per sub-group of elements on each side, and adds the scaled result into a running sum. Each element is a sign bit, two exponent bits and one mantissa bit. The operands arrive packed two elements per byte, with the element of even index in the low nibble.

A single mode pin picks one of two scaling schemes at runtime. In one scheme, each group of 16 elements carries an 8-bit E4M3 float scale. In the other, each group of 32 elements carries an 8-bit unsigned power-of-two UE8M0 scale. The element format is the same in both schemes. The products inside a group are summed exactly in fixed point and scaled only once per group, never per element. The running sum is held as a wide fixed-point value and is read out as an IEEE-754 single.

A host streams steps of one output element of a matrix tile with `i_valid`. It starts a fresh sum with `i_start` and zeroes the unit with `i_clear`. Tile scheduling and any tensor-wide scale stay outside the unit.

Top module: `fp4dot_unit`

## Requirements
- R1: Element i of an operand sits at bits [4i+3:4i]. Bit 3 is the sign. Codes 0 to 7 of bits [2:0] are the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6. Negative zero counts as zero.
- R2: With `i_mode`=0, group g is elements 16g to 16g+15. Its products are multiplied by the E4M3 scale byte g of each operand, held in bits [8g+7:8g]. An E4M3 byte is a sign, a 4-bit exponent with bias 7 and a 3-bit mantissa, and exponent 0 is subnormal (m/8 times 2^-6).
- R3: The E4M3 sign bit negates that scale, so a group whose two scales have opposite signs contributes with reversed sign.
- R4: With `i_mode`=1, group j (j=0,1) is elements 32j to 32j+31 and is scaled by 2^(e-127), where e is scale byte j. Scale bytes 2 and 3 have no effect in this mode, including the value 0xFF.
- R5: A step with `i_valid`=1 adds its dot product to the running sum. With `i_start` also high, the running sum is replaced by the step's dot product.
- R6: `i_clear` zeroes the running sum and the NaN flag and takes priority over `i_valid`. After reset the result is 0x00000000.
- R7: An E4M3 scale with its low seven bits all ones, or a UE8M0 scale of 0xFF, in a group that is in use sets a NaN flag. The flag drives the result to 0x7FC00000 and holds through later steps, including start steps, until `i_clear`.
- R8: `o_result` is the running sum converted to FP32 with round to nearest, ties to even. A zero sum reads as +0.
- R9: The running sum has a least significant bit of 2^-22. Mode-0 terms are always exact. A mode-1 term that falls below that weight is floored toward minus infinity. Mode-1 terms are exact up to a combined scale exponent of 28.
- R10: A cycle with neither `i_valid` nor `i_clear` leaves `o_result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_mode | input | 1 | 0: E4M3 scale per 16 elements; 1: UE8M0 scale per 32 elements |
| i_valid | input | 1 | Step qualifier |
| i_start | input | 1 | Replace rather than add the running sum |
| i_clear | input | 1 | Zero the running sum and NaN flag |
| i_a | input | 256 | Operand A, 64 packed E2M1 elements |
| i_b | input | 256 | Operand B, 64 packed E2M1 elements |
| i_a_scl | input | 32 | Operand A scale bytes, byte g for group g |
| i_b_scl | input | 32 | Operand B scale bytes, byte g for group g |
| o_result | output | 32 | Running sum as FP32 |

## Verification
The bench builds the unit with its defaults: 64 elements per step, 16-element small groups, and a 72-bit accumulator with 22 fraction bits. At that width every mode-0 scale combination is exact, so mode-0 expectations can be compared bit for bit. The mode-1 window reaches an integer part of 2^23, which lets the bench place a sum exactly on a single-precision tie and check that it rounds to even. At the low end, a 2^-54 term of each sign exercises the floor at the accumulator's least significant bit.

// File: rtl/fp4dot_pkg.sv
package fp4dot_pkg;

  typedef enum logic {
    SCL_E4M3  = 1'b0,
    SCL_UE8M0 = 1'b1
  } scl_mode_e;

  localparam logic [31:0] FP32_QNAN = 32'h7FC0_0000;

  // E2M1 code to signed value in half units (range -12..12)
  function automatic logic signed [4:0] e2m1_half(input logic [3:0] code);
    logic [3:0] mag;
    case (code[2:1])
      2'd0:    mag = {3'b000, code[0]};
      2'd1:    mag = {2'b00, 1'b1, code[0]};
      2'd2:    mag = {1'b0, 1'b1, code[0], 1'b0};
      default: mag = {1'b1, code[0], 2'b00};
    endcase
    if (code[3]) e2m1_half = -$signed({1'b0, mag});
    else         e2m1_half =  $signed({1'b0, mag});
  endfunction

endpackage

// File: rtl/fp4dot_grp_sum.sv
module fp4dot_grp_sum
  import fp4dot_pkg::*;
#(
  parameter int GRP   = 16,
  parameter int SUM_W = 14
) (
  input  logic [4*GRP-1:0]        i_a,
  input  logic [4*GRP-1:0]        i_b,
  output logic signed [SUM_W-1:0] o_sum
);

  // Exact sum of GRP products, in quarter units
  always_comb begin
    logic signed [SUM_W-1:0] s;
    logic signed [SUM_W-1:0] pa;
    logic signed [SUM_W-1:0] pb;
    s = '0;
    for (int i = 0; i < GRP; i++) begin
      pa = SUM_W'(e2m1_half(i_a[4*i +: 4]));
      pb = SUM_W'(e2m1_half(i_b[4*i +: 4]));
      s  = s + pa * pb;
    end
    o_sum = s;
  end

endmodule

// File: rtl/fp4dot_scale_pair.sv
module fp4dot_scale_pair
  import fp4dot_pkg::*;
(
  input  logic               i_mode,
  input  logic [7:0]         i_sa,
  input  logic [7:0]         i_sb,
  output logic signed [8:0]  o_mant,
  output logic signed [9:0]  o_exp,
  output logic               o_nan
);

  // Combined scale = o_mant * 2^o_exp
  always_comb begin
    logic [3:0] ma, mb;
    int         ea, eb;
    logic [7:0] mp;
    if (scl_mode_e'(i_mode) == SCL_E4M3) begin
      ma = {(i_sa[6:3] != 4'd0), i_sa[2:0]};
      mb = {(i_sb[6:3] != 4'd0), i_sb[2:0]};
      ea = (i_sa[6:3] == 4'd0) ? 1 : int'(i_sa[6:3]);
      eb = (i_sb[6:3] == 4'd0) ? 1 : int'(i_sb[6:3]);
      mp = ma * mb;
      o_mant = (i_sa[7] ^ i_sb[7]) ? -$signed({1'b0, mp}) : $signed({1'b0, mp});
      o_exp  = 10'(ea + eb - 20);
      o_nan  = (i_sa[6:0] == 7'h7F) || (i_sb[6:0] == 7'h7F);
    end else begin
      ma = '0;
      mb = '0;
      ea = int'(i_sa);
      eb = int'(i_sb);
      mp = '0;
      o_mant = 9'sd1;
      o_exp  = 10'(ea + eb - 254);
      o_nan  = (i_sa == 8'hFF) || (i_sb == 8'hFF);
    end
  end

endmodule

// File: rtl/fp4dot_to_fp32.sv
module fp4dot_to_fp32 #(
  parameter int W    = 72,
  parameter int FRAC = 22
) (
  input  logic signed [W-1:0] i_acc,
  input  logic                i_nan,
  output logic [31:0]         o_fp
);

  always_comb begin
    logic [W-1:0] mag;
    logic [W-2:0] norm;
    logic [30:0]  body;
    logic         guard, sticky, rnd;
    int           p;
    mag = i_acc[W-1] ? W'(-i_acc) : W'(i_acc);
    p = 0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) p = i;
    end
    norm   = (W-1)'(mag << (W - 1 - p));
    guard  = norm[W-25];
    sticky = |norm[W-26:0];
    body   = {8'(p - FRAC + 127), norm[W-2 -: 23]};
    rnd    = guard & (sticky | body[0]);
    body   = body + 31'(rnd);
    if (i_nan)          o_fp = 32'h7FC0_0000;
    else if (mag == '0) o_fp = 32'h0000_0000;
    else                o_fp = {i_acc[W-1], body};
  end

endmodule

// File: rtl/fp4dot_unit.sv
module fp4dot_unit
  import fp4dot_pkg::*;
#(
  parameter int N_ELEM   = 64,
  parameter int GRP_S    = 16,
  parameter int ACC_W    = 72,
  parameter int ACC_FRAC = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  i_mode,
  input  logic                  i_valid,
  input  logic                  i_start,
  input  logic                  i_clear,
  input  logic [4*N_ELEM-1:0]   i_a,
  input  logic [4*N_ELEM-1:0]   i_b,
  input  logic [8*(N_ELEM/GRP_S)-1:0] i_a_scl,
  input  logic [8*(N_ELEM/GRP_S)-1:0] i_b_scl,
  output logic [31:0]           o_result
);

  localparam int N_GRP    = N_ELEM / GRP_S;
  localparam int N_WIDE   = N_GRP / 2;
  localparam int GRP_BITS = 4 * GRP_S;
  localparam int SUM_W    = $clog2(144 * 2 * GRP_S + 1) + 1;
  localparam int PROD_W   = SUM_W + 9;
  localparam int SH_MAX   = ACC_W - 1 - PROD_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-group exact sums and scale decode
  logic signed [SUM_W-1:0] gsum [N_GRP];
  logic signed [8:0]       smant [N_GRP];
  logic signed [9:0]       sexp [N_GRP];
  logic [N_GRP-1:0]        snan;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    fp4dot_grp_sum #(.GRP(GRP_S), .SUM_W(SUM_W)) u_gsum (
      .i_a   (i_a[g*GRP_BITS +: GRP_BITS]),
      .i_b   (i_b[g*GRP_BITS +: GRP_BITS]),
      .o_sum (gsum[g])
    );
    fp4dot_scale_pair u_scl (
      .i_mode (i_mode),
      .i_sa   (i_a_scl[8*g +: 8]),
      .i_sb   (i_b_scl[8*g +: 8]),
      .o_mant (smant[g]),
      .o_exp  (sexp[g]),
      .o_nan  (snan[g])
    );
  end

  // slot selection, scaling and alignment into accumulator units
  logic signed [ACC_W-1:0] step_sum;
  logic                    step_nan;

  always_comb begin
    logic signed [SUM_W-1:0]  ssum;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  ext;
    logic                     snan_g;
    int                       k;
    step_sum = '0;
    step_nan = 1'b0;
    for (int g = 0; g < N_GRP; g++) begin
      if (scl_mode_e'(i_mode) == SCL_UE8M0) begin
        if (g < N_WIDE) begin
          ssum   = gsum[2*g] + gsum[2*g+1];
          snan_g = snan[g];
        end else begin
          ssum   = '0;
          snan_g = 1'b0;
        end
      end else begin
        ssum   = gsum[g];
        snan_g = snan[g];
      end
      prod = PROD_W'(ssum) * PROD_W'(smant[g]);
      ext  = ACC_W'(prod);
      k    = int'(sexp[g]) - 2 + ACC_FRAC;
      if (k >= 0) ext = ext <<< ((k > SH_MAX) ? SH_MAX : k);
      else        ext = ext >>> ((-k > ACC_W - 1) ? ACC_W - 1 : -k);
      step_sum = step_sum + ext;
      step_nan = step_nan | snan_g;
    end
  end

  // accumulator next state
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    nan_q, nan_d;
  logic                    acc_en;

  always_comb begin
    acc_en = i_clear | i_valid;
    if (i_clear) begin
      acc_d = '0;
      nan_d = 1'b0;
    end else begin
      acc_d = (i_start ? '0 : acc_q) + step_sum;
      nan_d = nan_q | step_nan;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q <= '0;
      nan_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      nan_q <= nan_d;
    end
  end

  fp4dot_to_fp32 #(.W(ACC_W), .FRAC(ACC_FRAC)) u_cvt (
    .i_acc (acc_q),
    .i_nan (nan_q),
    .o_fp  (o_result)
  );

endmodule

// File: rtl/fp4dot_unit_chk.sv
module fp4dot_unit_chk #(
  parameter int N_ELEM = 64,
  parameter int GRP_S  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  i_mode,
  input logic                  i_valid,
  input logic                  i_clear,
  input logic [8*(N_ELEM/GRP_S)-1:0] i_a_scl,
  input logic [31:0]           o_result
);

  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  // R6: clear gives +0 on the next cycle
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    i_clear |=> (o_result == 32'h0000_0000));

  // R10: idle cycles hold the result
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_valid && !i_clear) |=> $stable(o_result));

  // R7: an E4M3 NaN scale on group 0 of A forces NaN
  a_r7_nan_set: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_clear && !i_mode && (i_a_scl[6:0] == 7'h7F)) |=> (o_result == QNAN));

  // R7: NaN stays until a clear
  a_r7_nan_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((o_result == QNAN) && !i_clear) |=> (o_result == QNAN));

  // R8: zero never reads as negative zero
  a_r8_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    o_result != 32'h8000_0000);

endmodule

bind fp4dot_unit fp4dot_unit_chk #(.N_ELEM(N_ELEM), .GRP_S(GRP_S)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .i_mode   (i_mode),
  .i_valid  (i_valid),
  .i_clear  (i_clear),
  .i_a_scl  (i_a_scl),
  .o_result (o_result)
);

// File: tb/fp4dot_unit_tb.sv
module fp4dot_unit_tb;

  typedef struct packed {
    logic         mode;
    logic [255:0] a;
    logic [255:0] b;
    logic [31:0]  sa;
    logic [31:0]  sb;
    logic [31:0]  expv;
  } vec_t;

  // every vector is applied as a start step
  localparam vec_t VECS [10] = '{
    '{1'b0, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838, 32'h4280_0000}, // R1 R2: 64
    '{1'b0, {64{4'h2}}, {64{4'h2}}, 32'h3C30_4038, 32'h3838_3838, 32'h42A0_0000}, // R2: 80
    '{1'b0, {64{4'hA}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838, 32'hC280_0000}, // R1: -64
    '{1'b0, {64{4'h2}}, {64{4'h2}}, 32'h3838_38B8, 32'h3838_3838, 32'h4200_0000}, // R3: 32
    '{1'b0, {16{16'h7654}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838, 32'h4370_0000}, // R1: 240
    '{1'b0, {64{4'h2}}, {64{4'h2}}, 32'h0101_0101, 32'h3838_3838, 32'h3E00_0000}, // R2 subnormal
    '{1'b1, {64{4'h2}}, {64{4'h2}}, 32'h5555_807F, 32'hFFFF_7F7F, 32'h42C0_0000}, // R4: 96
    '{1'b1, {64{4'h1}}, {64{4'h3}}, 32'h0000_7E7E, 32'h0000_7F7F, 32'h41C0_0000}, // R4: 24
    '{1'b0, {64{4'h8}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838, 32'h0000_0000}, // R1 R8: -0
    '{1'b0, {64{4'h7}}, {64{4'hF}}, 32'h3838_3838, 32'h3838_3838, 32'hC510_0000}  // R1: -2304
  };

  logic         clk;
  logic         rst_n;
  logic         i_mode, i_valid, i_start, i_clear;
  logic [255:0] i_a, i_b;
  logic [31:0]  i_a_scl, i_b_scl;
  logic [31:0]  o_result;

  int n_chk = 0;
  int n_bad = 0;

  fp4dot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .i_mode(i_mode), .i_valid(i_valid),
    .i_start(i_start), .i_clear(i_clear), .i_a(i_a), .i_b(i_b),
    .i_a_scl(i_a_scl), .i_b_scl(i_b_scl), .o_result(o_result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic step(input logic mode, input logic start, input logic clr, input logic vld,
                      input logic [255:0] a, input logic [255:0] b,
                      input logic [31:0] sa, input logic [31:0] sb);
    @(negedge clk);
    i_mode = mode; i_start = start; i_clear = clr; i_valid = vld;
    i_a = a; i_b = b; i_a_scl = sa; i_b_scl = sb;
    @(posedge clk);
    #1;
    i_valid = 1'b0; i_clear = 1'b0; i_start = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_mode = 1'b0; i_valid = 1'b0; i_start = 1'b0; i_clear = 1'b0;
    i_a = '0; i_b = '0; i_a_scl = '0; i_b_scl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R6 reset", o_result, 32'h0000_0000);

    for (int i = 0; i < 10; i++) begin
      step(VECS[i].mode, 1'b1, 1'b0, 1'b1, VECS[i].a, VECS[i].b, VECS[i].sa, VECS[i].sb);
      check("R1 R2 R3 R4 R8 table", o_result, VECS[i].expv);
    end

    // R5: accumulate and replace
    step(1'b0, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838);
    step(1'b0, 1'b0, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838);
    check("R5 accumulate", o_result, 32'h4300_0000);
    // R10: idle with changing inputs
    step(1'b1, 1'b1, 1'b0, 1'b0, {64{4'h7}}, {64{4'h7}}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10 idle hold", o_result, 32'h4300_0000);
    step(1'b0, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838);
    check("R5 start replaces", o_result, 32'h4280_0000);
    // R6: clear over valid
    step(1'b0, 1'b0, 1'b1, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838);
    check("R6 clear priority", o_result, 32'h0000_0000);

    // R7: NaN set, sticky across start, removed by clear
    step(1'b0, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h387F_3838, 32'h3838_3838);
    check("R7 e4m3 nan", o_result, 32'h7FC0_0000);
    step(1'b0, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'h3838_3838);
    check("R7 nan sticky", o_result, 32'h7FC0_0000);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, '0);
    check("R7 nan cleared", o_result, 32'h0000_0000);
    step(1'b0, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h3838_3838, 32'hFF38_3838);
    check("R7 negative nan code", o_result, 32'h7FC0_0000);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, '0);
    step(1'b1, 1'b1, 1'b0, 1'b1, {64{4'h2}}, {64{4'h2}}, 32'h0000_FF7F, 32'h0000_7F7F);
    check("R7 ue8m0 nan", o_result, 32'h7FC0_0000);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, '0);

    // R8: ties to even at 2^23
    step(1'b1, 1'b1, 1'b0, 1'b1, 256'h2 | (256'h1 << 128), 256'h2 | (256'h2 << 128),
         32'h0000_7F96, 32'h0000_7F7F);
    check("R8 tie down to even", o_result, 32'h4B00_0000);
    step(1'b1, 1'b0, 1'b0, 1'b1, 256'h2 << 128, 256'h2 << 128, 32'h0000_7F7F, 32'h0000_7F7F);
    check("R8 tie up to even", o_result, 32'h4B00_0002);

    // R9: floor below the accumulator lsb
    step(1'b1, 1'b1, 1'b0, 1'b1, 256'h9, 256'h1, 32'h0000_0064, 32'h0000_0064);
    check("R9 floor negative", o_result, 32'hB480_0000);
    step(1'b1, 1'b1, 1'b0, 1'b1, 256'h1, 256'h1, 32'h0000_0064, 32'h0000_0064);
    check("R9 floor positive", o_result, 32'h0000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule